// File: doc/BRIEF.md
# Linked Pattern Chain Output Sequencer

The block keeps a bank of twelve 16-bit pattern words. Each word holds a 2-bit waveform code for each of six output pins and, in its top four bits, the index of the word that is to be loaded after it. Each rising edge of a load strobe copies the word named by the pointer in the active register into that active register. The words therefore form a chain that runs through the bank one strobe at a time. The active register drives the pins. Each pin is forced low, forced high, follows a PWM input, or follows its inverse.

A host fills the bank through a synchronous write port and reads it back through a combinational read port. The PWM source and the strobe source are outside the block. A pointer value of 12 or above is illegal. When a strobe meets such a pointer, no load takes place and an error pulse is raised instead.

Top module: `pattern_chain_seq`

## Requirements
- R1: While reset is asserted at a clock edge, all twelve bank words and the active register become zero. After reset all pins are low, `ptr_err` is low and the pointer names word 0.
- R2: A write with `host_wr_en` high and `host_wr_idx` in 0..11 stores `host_wr_word` at that clock edge. `host_rd_word` shows the word at `host_rd_idx` combinationally. A write to index 12..15 is ignored, and a read of index 12..15 returns zero.
- R3: A rising edge of `load_strobe` is detected at the first clock edge where the strobe is high after a cycle in which it was low. At that edge the word named by the current pointer is copied into the active register. Holding the strobe high causes no further load.
- R4: Bits 15:12 of the active word are the pointer to the next word (bit 15 is the upper bank bit). Successive strobes therefore walk the chain that these fields link.
- R5: Pin p is controlled by active bits [2p+1:2p]. Pin 5 uses bits 11:10 and pin 4 uses bits 9:8. Code 00 drives the pin low, 01 passes `pwm_in`, 10 passes the inverse of `pwm_in`, and 11 drives the pin high.
- R6: The pins follow a change of `pwm_in` within the same cycle, with no register in the path.
- R7: If a strobe edge is detected while the pointer is 12..15, `ptr_err` is high for exactly the following cycle and the active register keeps its value.
- R8: A host write never changes the active register. A write to the word being loaded at the same clock edge affects only later loads; the load copies the earlier content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr_en | input | 1 | Host write enable |
| host_wr_idx | input | 4 | Host write index |
| host_wr_word | input | 16 | Host write data |
| host_rd_idx | input | 4 | Host read index |
| host_rd_word | output | 16 | Word at the read index, zero if out of range |
| load_strobe | input | 1 | Load request; its rising edge loads the next word |
| pwm_in | input | 1 | PWM waveform to pass or invert |
| pin_out | output | 6 | Pattern pins |
| ptr_err | output | 1 | One-cycle pulse on a strobe that meets an illegal pointer |

## Verification
The bench builds the block with its default parameters: twelve entries, a 4-bit pointer and six pins. With these values the pointer codes 12 to 15 can be written, so the error path and the stuck chain after it can be reached. The bench links a chain through words 0, 3, 7 and 11, with the upper bank bit set on the last links, into an illegal pointer, and checks every waveform code with both PWM levels. It also drives a strobe held high, a host write in the same cycle as a load, and a reset in the middle of the run.

// File: rtl/pcs_pkg.sv
// Package: shared waveform code type and the pin decode function of the
// pattern chain sequencer. Assumes 2-bit codes per pin.
package pcs_pkg;

    typedef enum logic [1:0] {
        WAVE_LOW  = 2'b00,
        WAVE_PWM  = 2'b01,
        WAVE_INV  = 2'b10,
        WAVE_HIGH = 2'b11
    } wave_e;

    // Resolve one pin level from its code and the PWM level.
    function automatic logic wave_level(input logic [1:0] code, input logic pwm);
        case (wave_e'(code))
            WAVE_LOW:  wave_level = 1'b0;
            WAVE_PWM:  wave_level = pwm;
            WAVE_INV:  wave_level = ~pwm;
            default:   wave_level = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pcs_entry_bank.sv
// Entry bank: N_ENTRIES words of flops with a host write port and two
// combinational read ports (host readback and the load path).
// Assumes: indices at or above N_ENTRIES are ignored on write and read as zero.
module pcs_entry_bank #(
    parameter int N_ENTRIES = 12,
    parameter int WORD_W    = 16,
    parameter int IDX_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    input  logic [IDX_W-1:0]  ld_idx,
    output logic [WORD_W-1:0] ld_word,
    output logic              ld_valid
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

    logic [WORD_W-1:0] mem [N_ENTRIES];

    // One register per entry, written only when its index matches.
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                mem[g] <= wr_word;
            end
        end
    end

    // Host readback multiplexer; out-of-range indices yield zero.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (rd_idx == IDX_W'(i)) rd_word = mem[i];
        end
    end

    // Load-path multiplexer plus legality of the requested index.
    always_comb begin
        ld_word = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (ld_idx == IDX_W'(i)) ld_word = mem[i];
        end
    end

    assign ld_valid = (ld_idx <= LAST_IDX);

    AST_RD_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx > LAST_IDX) |-> (rd_word == '0)); // R2

    AST_WR_NOT_SEEN_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == ld_idx) && ld_valid && (wr_word != ld_word))
            |=> (ld_word != $past(ld_word)) || (ld_idx != $past(ld_idx))); // R8

endmodule

// File: rtl/pcs_load_ctrl.sv
// Load controller: detects the rising edge of the load strobe and copies the
// word at the current pointer into the active register, or raises a
// one-cycle error when the pointer is out of range.
// Assumes: the strobe is synchronous to clk.
module pcs_load_ctrl #(
    parameter int WORD_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              ld_valid,
    output logic [WORD_W-1:0] active_word,
    output logic [IDX_W-1:0]  next_ptr,
    output logic              err_pulse
);
    logic              strobe_q;
    logic              rise;
    logic [WORD_W-1:0] active_q;

    assign rise = strobe & ~strobe_q;

    // Strobe history, active register update and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q  <= 1'b0;
            active_q  <= '0;
            err_pulse <= 1'b0;
        end else begin
            strobe_q  <= strobe;
            err_pulse <= rise & ~ld_valid;
            if (rise && ld_valid) active_q <= ld_word;
        end
    end

    assign active_word = active_q;
    assign next_ptr    = active_q[WORD_W-1 -: IDX_W];

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse); // R7

    AST_ERR_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $stable(active_q)); // R7

    AST_NO_EDGE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(active_q)); // R3

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && ld_valid) |=> (active_q == $past(ld_word))); // R3

endmodule

// File: rtl/pcs_pin_stage.sv
// Pin stage: purely combinational decode of per-pin waveform codes against
// the PWM input. Assumes codes are packed with pin p at bits [2p+1:2p].
module pcs_pin_stage
    import pcs_pkg::*;
#(
    parameter int N_PINS = 6
) (
    input  logic [2*N_PINS-1:0] codes,
    input  logic                pwm,
    output logic [N_PINS-1:0]   pins
);
    // One selector per pin.
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        assign pins[p] = wave_level(codes[2*p +: 2], pwm);
    end

endmodule

// File: rtl/pattern_chain_seq.sv
// Top: linked pattern chain sequencer. Ties the entry bank, the load
// controller and the pin stage together.
// Assumes: WORD_W >= IDX_W + 2*N_PINS; pointer sits in the top IDX_W bits.
module pattern_chain_seq #(
    parameter int N_ENTRIES = 12,
    parameter int WORD_W    = 16,
    parameter int IDX_W     = 4,
    parameter int N_PINS    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [IDX_W-1:0]  host_wr_idx,
    input  logic [WORD_W-1:0] host_wr_word,
    input  logic [IDX_W-1:0]  host_rd_idx,
    output logic [WORD_W-1:0] host_rd_word,
    input  logic              load_strobe,
    input  logic              pwm_in,
    output logic [N_PINS-1:0] pin_out,
    output logic              ptr_err
);
    localparam int CODE_W = 2 * N_PINS;

    logic [WORD_W-1:0] ld_word;
    logic              ld_valid;
    logic [WORD_W-1:0] active_word;
    logic [IDX_W-1:0]  next_ptr;

    pcs_entry_bank #(
        .N_ENTRIES (N_ENTRIES),
        .WORD_W    (WORD_W),
        .IDX_W     (IDX_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr_en),
        .wr_idx   (host_wr_idx),
        .wr_word  (host_wr_word),
        .rd_idx   (host_rd_idx),
        .rd_word  (host_rd_word),
        .ld_idx   (next_ptr),
        .ld_word  (ld_word),
        .ld_valid (ld_valid)
    );

    pcs_load_ctrl #(
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) u_load (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe      (load_strobe),
        .ld_word     (ld_word),
        .ld_valid    (ld_valid),
        .active_word (active_word),
        .next_ptr    (next_ptr),
        .err_pulse   (ptr_err)
    );

    pcs_pin_stage #(
        .N_PINS (N_PINS)
    ) u_pins (
        .codes (active_word[CODE_W-1:0]),
        .pwm   (pwm_in),
        .pins  (pin_out)
    );

    AST_WRITE_KEEPS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && !load_strobe) |=> $stable(active_word)); // R8

    AST_ERR_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_err |-> $past(load_strobe)); // R7

endmodule

// File: tb/pattern_chain_seq_bench.sv
// Scoreboard bench: driver tasks update a reference model and push the
// expected outputs; a monitor pops and compares them at each falling edge.
module pattern_chain_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [3:0]  host_wr_idx = '0;
    logic [15:0] host_wr_word = '0;
    logic [3:0]  host_rd_idx = '0;
    logic [15:0] host_rd_word;
    logic        load_strobe = 1'b0;
    logic        pwm_in = 1'b0;
    logic [5:0]  pin_out;
    logic        ptr_err;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pattern_chain_seq u_pattern_chain_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_en   (host_wr_en),
        .host_wr_idx  (host_wr_idx),
        .host_wr_word (host_wr_word),
        .host_rd_idx  (host_rd_idx),
        .host_rd_word (host_rd_word),
        .load_strobe  (load_strobe),
        .pwm_in       (pwm_in),
        .pin_out      (pin_out),
        .ptr_err      (ptr_err)
    );

    typedef struct {
        logic [5:0]  pins;
        logic        err;
        logic [15:0] rd;
        string       tag;
    } item_t;

    item_t       sb[$];
    logic [15:0] m_ent [12];
    logic [15:0] m_act;

    // Reference pin model built from the code table.
    function automatic logic [5:0] exp_pins(input logic [15:0] w, input logic pwm);
        logic [5:0] r;
        for (int p = 0; p < 6; p++) begin
            case (w[2*p +: 2])
                2'b00:   r[p] = 1'b0;
                2'b01:   r[p] = pwm;
                2'b10:   r[p] = ~pwm;
                default: r[p] = 1'b1;
            endcase
        end
        return r;
    endfunction

    function automatic logic [15:0] model_rd(input logic [3:0] idx);
        return (idx < 4'd12) ? m_ent[idx] : 16'h0000;
    endfunction

    function automatic logic [15:0] mk(input logic [3:0] ptr, input logic [1:0] c5,
            input logic [1:0] c4, input logic [1:0] c3, input logic [1:0] c2,
            input logic [1:0] c1, input logic [1:0] c0);
        return {ptr, c5, c4, c3, c2, c1, c0};
    endfunction

    task automatic push(input string tag);
        item_t it;
        it.pins = exp_pins(m_act, pwm_in);
        it.err  = 1'b0;
        it.rd   = model_rd(host_rd_idx);
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic push_err(input string tag);
        item_t it;
        it.pins = exp_pins(m_act, pwm_in);
        it.err  = 1'b1;
        it.rd   = model_rd(host_rd_idx);
        it.tag  = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare one expected item per falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (pin_out !== it.pins || ptr_err !== it.err || host_rd_word !== it.rd) begin
                bad++;
                $display("FAIL %s: pins=%b err=%b rd=%h expected pins=%b err=%b rd=%h",
                         it.tag, pin_out, ptr_err, host_rd_word, it.pins, it.err, it.rd);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 12; i++) m_ent[i] = '0;
        m_act = '0;
    endtask

    task automatic do_write(input logic [3:0] idx, input logic [15:0] w, input string tag);
        step();
        host_wr_en   = 1'b1;
        host_wr_idx  = idx;
        host_wr_word = w;
        host_rd_idx  = idx;
        load_strobe  = 1'b0;
        if (idx < 4'd12) m_ent[idx] = w;
        push(tag);
        step();
        host_wr_en = 1'b0;
    endtask

    // Strobe edge, one cycle held high, then release.
    task automatic do_load(input bit also_wr, input logic [15:0] w, input string tag);
        logic [3:0]  idx;
        logic [15:0] old;
        idx = m_act[15:12];
        step();
        load_strobe = 1'b1;
        host_rd_idx = idx;
        if (also_wr) begin
            host_wr_en   = 1'b1;
            host_wr_idx  = idx;
            host_wr_word = w;
        end
        if (idx < 4'd12) begin
            old   = m_ent[idx];
            m_act = old;
            if (also_wr) m_ent[idx] = w;
            push(tag);
        end else begin
            push_err({tag, " R7 illegal pointer"});
        end
        step();
        host_wr_en = 1'b0;
        push("R3 strobe held high, no reload");
        step();
        load_strobe = 1'b0;
    endtask

    // Toggle PWM and check pins before any clock edge.
    task automatic pwm_check(input string tag);
        for (int k = 0; k < 2; k++) begin
            step();
            pwm_in = ~pwm_in;
            #1;
            total++;
            if (pin_out !== exp_pins(m_act, pwm_in)) begin
                bad++;
                $display("FAIL %s: pins=%b expected %b (pwm=%b)", tag, pin_out,
                         exp_pins(m_act, pwm_in), pwm_in);
            end
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        step();
        rst_n = 1'b1;
        push("R1 reset state");
        pwm_check("R1 reset pins low");

        // R2: fill a chain 0 -> 3 -> 7 -> 11 -> 12 (illegal)
        do_write(4'd0,  mk(4'd3,  2'b11, 2'b00, 2'b01, 2'b10, 2'b11, 2'b00), "R2 write e0");
        do_write(4'd3,  mk(4'd7,  2'b01, 2'b10, 2'b00, 2'b11, 2'b01, 2'b10), "R2 write e3");
        do_write(4'd7,  mk(4'd11, 2'b10, 2'b11, 2'b11, 2'b01, 2'b00, 2'b01), "R2 write e7");
        do_write(4'd11, mk(4'd12, 2'b00, 2'b01, 2'b10, 2'b00, 2'b10, 2'b11), "R2 write e11");
        do_write(4'd13, 16'hBEEF, "R2 out-of-range write ignored, read zero");
        do_write(4'd12, 16'h1234, "R2 index 12 write ignored");
        step();
        host_rd_idx = 4'd0;
        push("R8 writes leave pins low");

        do_load(1'b0, '0, "R4 load e0");
        pwm_check("R5 R6 codes of e0");
        do_load(1'b0, '0, "R4 load e3");
        pwm_check("R5 R6 codes of e3");
        do_load(1'b0, '0, "R4 load e7");
        pwm_check("R5 codes of e7");
        do_load(1'b0, '0, "R4 load e11");
        pwm_check("R5 codes of e11");
        do_load(1'b0, '0, "R7 first illegal strobe");
        pwm_check("R7 pins held after error");
        do_load(1'b0, '0, "R7 second illegal strobe");

        // Reset mid-run, then same-edge write and load
        step();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        model_reset();
        host_rd_idx = 4'd3;
        push("R1 reset clears bank and active");
        do_write(4'd0, mk(4'd0, 2'b11, 2'b11, 2'b01, 2'b10, 2'b00, 2'b11), "R2 write self-link e0");
        do_load(1'b1, mk(4'd0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00), "R8 load with same-edge write");
        pwm_check("R8 old content loaded");
        do_load(1'b0, '0, "R8 new content on next load");
        pwm_check("R5 all-low after reload");
        step();
        step();
        step();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule